// File: doc/BRIEF.md
# System Configuration Register Bank

This block is a small bank of control and identification words behind a 32-bit peripheral bus. Each transfer has a setup phase and an access phase and adds no wait states. The bank occupies a 4 KB window. It holds up to eight general configuration words, a clock-lock status word with a writable mask byte, and three constant identification words. A 12-bit variant code, taken from bits [15:4] of the identification word, decides which configuration words exist. It also decides whether the first two configuration words drive the remap line and the LED vector.

Software writes configuration words to steer board-level behaviour. Absent words read as zero and ignore writes, and no error is signalled. The lock word reports a set of per-loop locked flags, which are fixed by a parameter. It also reports a summary bit that covers only the loops chosen by the mask byte.

Top module: `sysctl_regbank`

## Requirements
- R1: At reset the word at 0x00 loads parameter CFG0_RESET, the words at 0x04, 0x08, 0x14, 0x18 and 0x1C clear to zero, and the lock mask (bits [31:24] of 0x100) loads 0xFF. With all locked flags set, 0x100 reads 0xFFFF0001.
- R2: The words at 0x00 and 0x04 exist for every variant and store all 32 written bits.
- R3: The words at 0x08 and 0x14 exist only when the variant code (ID_VALUE[15:4]) is 0x524, 0x547 or 0x536.
- R4: The word at 0x0C exists only for variant codes other than 0x524, 0x547 and 0x536. It always reads as zero and ignores writes.
- R5: The word at 0x18 exists only for variant codes 0x524 and 0x536. The word at 0x1C exists only for variant code 0x536, and a write to 0x1C changes no other word.
- R6: 0x10 reads CFG4_VALUE, 0xFF8 reads AID_VALUE and 0xFFC reads ID_VALUE. Writes to these offsets have no effect.
- R7: A read of an absent word or of an unmapped offset returns zero, and a write there changes nothing.
- R8: For variant codes other than 0x536, each write to 0x00 puts bit 0 of the written value on remap_o from the next clock. After reset remap_o equals CFG0_RESET[0]. For variant 0x536, remap_o stays 0.
- R9: For variant codes other than 0x536, led_o[i] equals bit i of the word at 0x04. For variant 0x536, led_o stays 0.
- R10: A write to 0x100 changes only bits [31:24] of that word. Bits [23:16] read the DLL_LOCKED parameter, and bits [15:1] read zero.
- R11: Bit 0 of 0x100 reads 1 exactly when every locked flag selected by a set mask bit is 1. It therefore reads 1 when the mask is zero.
- R12: While psel is high and pwrite is low, prdata shows the addressed word in the same cycle. In every other cycle prdata is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | Peripheral select |
| penable | input | 1 | Access phase strobe |
| pwrite | input | 1 | 1 = write transfer |
| paddr | input | ADDR_W | Byte offset in the window |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, zero wait states |
| remap_o | output | 1 | Remap control line |
| led_o | output | NUM_LEDS | Active-high LED drives |

## Verification
The bench builds three copies of the block that share one bus. Their variant codes are 0x524, 0x536 and 0x511, so each presence rule is seen both present and absent. Each copy has a distinct lock-flag pattern (0xFF, 0x5A, 0xF0), which lets the summary bit take both values. A sweep writes every mapped offset and a set of unmapped ones, and after each write it reads back all offsets on all copies. All 256 mask values are then written and the summary bit is checked arithmetically.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;
    localparam int DATA_W    = 32;
    localparam int CFG_COUNT = 8;
    localparam int DLL_W     = 8;

    typedef enum logic [3:0] {
        SEL_CFG0, SEL_CFG1, SEL_CFG2, SEL_CFG3,
        SEL_CFG4, SEL_CFG5, SEL_CFG6, SEL_CFG7,
        SEL_DLL, SEL_AID, SEL_ID, SEL_NONE
    } reg_sel_e;

    typedef struct packed {
        logic [CFG_COUNT-1:0][DATA_W-1:0] cfg;
        logic [DLL_W-1:0]                 dll_mask;
        logic                             remap;
    } bank_state_t;

    function automatic logic variant_is_a(input logic [11:0] v);
        return (v == 12'h524) || (v == 12'h547) || (v == 12'h536);
    endfunction

    function automatic logic cfg_present(input int idx, input logic [11:0] v);
        case (idx)
            2, 5:    return variant_is_a(v);
            3:       return !variant_is_a(v);
            6:       return (v == 12'h524) || (v == 12'h536);
            7:       return (v == 12'h536);
            default: return 1'b1;
        endcase
    endfunction
endpackage

// File: rtl/sysctl_addr_decode.sv
module sysctl_addr_decode
    import sysctl_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic [ADDR_W-1:0] paddr,
    input  logic [11:0]       variant,
    output reg_sel_e          sel,
    output logic              present
);
    localparam int WORD_W = ADDR_W - 2;
    localparam logic [WORD_W-1:0] W_DLL = WORD_W'(12'h100 >> 2);
    localparam logic [WORD_W-1:0] W_AID = WORD_W'(12'hFF8 >> 2);
    localparam logic [WORD_W-1:0] W_ID  = WORD_W'(12'hFFC >> 2);

    logic [WORD_W-1:0]    word;
    logic [CFG_COUNT-1:0] cfg_hit;
    logic [CFG_COUNT-1:0] cfg_ok;

    assign word = paddr[ADDR_W-1:2];

    for (genvar g = 0; g < CFG_COUNT; g++) begin : g_cfg
        assign cfg_hit[g] = (word == WORD_W'(g));
        assign cfg_ok[g]  = cfg_present(g, variant);
    end

    always_comb begin
        sel     = SEL_NONE;
        present = 1'b0;
        for (int i = 0; i < CFG_COUNT; i++) begin
            if (cfg_hit[i]) begin
                sel     = reg_sel_e'(i);
                present = cfg_ok[i];
            end
        end
        if (word == W_DLL) begin
            sel = SEL_DLL; present = 1'b1;
        end else if (word == W_AID) begin
            sel = SEL_AID; present = 1'b1;
        end else if (word == W_ID) begin
            sel = SEL_ID;  present = 1'b1;
        end
    end
endmodule

// File: rtl/sysctl_dll_status.sv
module sysctl_dll_status
    import sysctl_pkg::*;
(
    input  logic [DLL_W-1:0]  mask,
    input  logic [DLL_W-1:0]  locked,
    output logic [DATA_W-1:0] word
);
    logic all_locked;

    assign all_locked = &(locked | ~mask);
    assign word = {mask, locked, {(DATA_W-2*DLL_W-1){1'b0}}, all_locked};
endmodule

// File: rtl/sysctl_regbank.sv
module sysctl_regbank
    import sysctl_pkg::*;
#(
    parameter int          ADDR_W     = 12,
    parameter int          NUM_LEDS   = 8,
    parameter logic [31:0] ID_VALUE   = 32'h4104_5110,
    parameter logic [31:0] AID_VALUE  = 32'h0000_0000,
    parameter logic [31:0] CFG4_VALUE = 32'h0000_0000,
    parameter logic [31:0] CFG0_RESET = 32'h0000_0000,
    parameter logic [7:0]  DLL_LOCKED = 8'hFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [31:0]       pwdata,
    output logic [31:0]       prdata,
    output logic              remap_o,
    output logic [NUM_LEDS-1:0] led_o
);
    localparam logic [11:0] VARIANT    = ID_VALUE[15:4];
    localparam logic        LEGACY_OUT = (VARIANT != 12'h536);

    function automatic bank_state_t reset_state();
        bank_state_t s;
        s          = '0;
        s.cfg[0]   = CFG0_RESET;
        s.dll_mask = '1;
        s.remap    = LEGACY_OUT ? CFG0_RESET[0] : 1'b0;
        return s;
    endfunction

    bank_state_t       state_d, state_q;
    reg_sel_e          sel;
    logic              present;
    logic              wr_en;
    logic [DATA_W-1:0] dll_word;

    sysctl_addr_decode #(.ADDR_W(ADDR_W)) u_decode (
        .paddr   (paddr),
        .variant (VARIANT),
        .sel     (sel),
        .present (present)
    );

    sysctl_dll_status u_dll (
        .mask   (state_q.dll_mask),
        .locked (DLL_LOCKED),
        .word   (dll_word)
    );

    assign wr_en = psel && penable && pwrite && present;

    always_comb begin
        state_d = state_q;
        if (wr_en) begin
            case (sel)
                SEL_CFG0: begin
                    state_d.cfg[0] = pwdata;
                    if (LEGACY_OUT) state_d.remap = pwdata[0];
                end
                SEL_CFG1: state_d.cfg[1] = pwdata;
                SEL_CFG2: state_d.cfg[2] = pwdata;
                SEL_CFG5: state_d.cfg[5] = pwdata;
                SEL_CFG6: state_d.cfg[6] = pwdata;
                SEL_CFG7: state_d.cfg[7] = pwdata;
                SEL_DLL:  state_d.dll_mask = pwdata[31:24];
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= reset_state();
        else        state_q <= state_d;
    end

    always_comb begin
        prdata = '0;
        if (psel && !pwrite && present) begin
            case (sel)
                SEL_CFG0, SEL_CFG1, SEL_CFG2, SEL_CFG5,
                SEL_CFG6, SEL_CFG7: prdata = state_q.cfg[sel[2:0]];
                SEL_CFG4: prdata = CFG4_VALUE;
                SEL_DLL:  prdata = dll_word;
                SEL_AID:  prdata = AID_VALUE;
                SEL_ID:   prdata = ID_VALUE;
                default:  prdata = '0;
            endcase
        end
    end

    assign remap_o = state_q.remap;
    assign led_o   = LEGACY_OUT ? state_q.cfg[1][NUM_LEDS-1:0] : '0;
endmodule

// File: rtl/sysctl_regbank_chk.sv
module sysctl_regbank_chk #(
    parameter int          ADDR_W     = 12,
    parameter int          NUM_LEDS   = 8,
    parameter logic [31:0] ID_VALUE   = 32'h0,
    parameter logic [7:0]  DLL_LOCKED = 8'hFF
) (
    input logic                clk,
    input logic                rst_n,
    input logic                psel,
    input logic                penable,
    input logic                pwrite,
    input logic [ADDR_W-1:0]   paddr,
    input logic [31:0]         pwdata,
    input logic [31:0]         prdata,
    input logic                remap_o,
    input logic [NUM_LEDS-1:0] led_o
);
    localparam logic legacy = (ID_VALUE[15:4] != 12'h536);
    logic [ADDR_W-3:0] w;
    logic wr, rd, unmapped;
    assign w  = paddr[ADDR_W-1:2];
    assign wr = psel && penable && pwrite;
    assign rd = psel && !pwrite;
    assign unmapped = (w > (ADDR_W-2)'(7)) && (w != (ADDR_W-2)'(12'h100 >> 2))
                      && (w != (ADDR_W-2)'(12'hFF8 >> 2)) && (w != (ADDR_W-2)'(12'hFFC >> 2));

    assert_unmapped_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rd && unmapped |-> prdata == 32'h0);
    assert_cfg3_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rd && w == (ADDR_W-2)'(3) |-> prdata == 32'h0);
    assert_idle_zero_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !rd |-> prdata == 32'h0);
    assert_remap_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr && w == '0) |=> $stable(remap_o));
    assert_remap_follow_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wr && w == '0 |=> remap_o == (legacy ? $past(pwdata[0]) : 1'b0));
    assert_led_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr && w == (ADDR_W-2)'(1)) |=> $stable(led_o));
    assert_led_follow_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wr && w == (ADDR_W-2)'(1) |=>
        led_o == (legacy ? $past(pwdata[NUM_LEDS-1:0]) : '0));
    assert_dll_flags_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rd && w == (ADDR_W-2)'(12'h100 >> 2) |->
        prdata[23:16] == DLL_LOCKED && prdata[15:1] == 15'h0);
endmodule

bind sysctl_regbank sysctl_regbank_chk #(
    .ADDR_W(ADDR_W), .NUM_LEDS(NUM_LEDS), .ID_VALUE(ID_VALUE), .DLL_LOCKED(DLL_LOCKED)
) u_chk (
    .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .remap_o(remap_o), .led_o(led_o)
);

// File: tb/test_sysctl_regbank.sv
module test_sysctl_regbank;
    localparam int NL = 4;
    logic clk = 1'b0, rst_n = 1'b0;
    logic psel = 0, penable = 0, pwrite = 0;
    logic [11:0] paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] rd [3];
    logic        rmp [3];
    logic [NL-1:0] led [3];
    int n_tests = 0, n_fail = 0;

    always #2.5 clk = ~clk;

    function automatic logic [31:0] idv(int k);
        return k == 0 ? 32'h4115_5240 : k == 1 ? 32'h4105_5360 : 32'h4104_5110;
    endfunction
    function automatic logic [31:0] aidv(int k);  return 32'hA1D0_0000 + k; endfunction
    function automatic logic [31:0] c4v(int k);   return 32'h0C40_0000 + k; endfunction
    function automatic logic [31:0] c0r(int k);   return k == 1 ? 32'h0000_0003 : 32'h1234_5671 + k; endfunction
    function automatic logic [7:0]  lkv(int k);   return k == 0 ? 8'hFF : k == 1 ? 8'h5A : 8'hF0; endfunction

    sysctl_regbank #(.ADDR_W(12), .NUM_LEDS(NL), .ID_VALUE(32'h4115_5240), .AID_VALUE(32'hA1D0_0000),
        .CFG4_VALUE(32'h0C40_0000), .CFG0_RESET(32'h1234_5671), .DLL_LOCKED(8'hFF)) i_sysctl_regbank (
        .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite), .paddr(paddr),
        .pwdata(pwdata), .prdata(rd[0]), .remap_o(rmp[0]), .led_o(led[0]));
    sysctl_regbank #(.ADDR_W(12), .NUM_LEDS(NL), .ID_VALUE(32'h4105_5360), .AID_VALUE(32'hA1D0_0001),
        .CFG4_VALUE(32'h0C40_0001), .CFG0_RESET(32'h0000_0003), .DLL_LOCKED(8'h5A)) i_sysctl_regbank_b (
        .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite), .paddr(paddr),
        .pwdata(pwdata), .prdata(rd[1]), .remap_o(rmp[1]), .led_o(led[1]));
    sysctl_regbank #(.ADDR_W(12), .NUM_LEDS(NL), .ID_VALUE(32'h4104_5110), .AID_VALUE(32'hA1D0_0002),
        .CFG4_VALUE(32'h0C40_0002), .CFG0_RESET(32'h1234_5673), .DLL_LOCKED(8'hF0)) i_sysctl_regbank_c (
        .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite), .paddr(paddr),
        .pwdata(pwdata), .prdata(rd[2]), .remap_o(rmp[2]), .led_o(led[2]));

    // bench model
    logic [31:0] mcfg [3][8];
    logic [7:0]  mmask [3];
    logic        mremap [3];

    function automatic logic [11:0] var_of(int k); logic [31:0] i; i = idv(k); return i[15:4]; endfunction
    function automatic logic grp_a(int k);
        return var_of(k) == 12'h524 || var_of(k) == 12'h547 || var_of(k) == 12'h536;
    endfunction
    function automatic logic has(int k, int idx);
        case (idx)
            2, 5: return grp_a(k);
            3: return !grp_a(k);
            6: return var_of(k) == 12'h524 || var_of(k) == 12'h536;
            7: return var_of(k) == 12'h536;
            default: return 1'b1;
        endcase
    endfunction

    function automatic logic [31:0] exp_rd(int k, logic [11:0] a);
        logic [7:0] m;
        m = mmask[k];
        if (a < 12'h20) begin
            int idx; idx = int'(a >> 2);
            if (!has(k, idx) || idx == 3) return 32'h0;
            if (idx == 4) return c4v(k);
            return mcfg[k][idx];
        end
        if (a == 12'h100) return {m, lkv(k), 15'h0, &(lkv(k) | ~m)};
        if (a == 12'hFF8) return aidv(k);
        if (a == 12'hFFC) return idv(k);
        return 32'h0;
    endfunction

    task automatic model_wr(logic [11:0] a, logic [31:0] d);
        for (int k = 0; k < 3; k++) begin
            if (a < 12'h20) begin
                int idx; idx = int'(a >> 2);
                if (has(k, idx) && idx != 3 && idx != 4) mcfg[k][idx] = d;
                if (idx == 0 && var_of(k) != 12'h536) mremap[k] = d[0];
            end else if (a == 12'h100) mmask[k] = d[31:24];
        end
    endtask

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_wr(logic [11:0] a, logic [31:0] d);
        @(negedge clk); psel = 1; pwrite = 1; penable = 0; paddr = a; pwdata = d;
        @(negedge clk); penable = 1;
        @(negedge clk); psel = 0; penable = 0; pwrite = 0;
        model_wr(a, d);
    endtask

    // read all three copies at one offset and compare; tag names the requirement
    task automatic bus_rd_chk(logic [11:0] a, string req);
        @(negedge clk); psel = 1; pwrite = 0; penable = 0; paddr = a;
        #1;
        for (int k = 0; k < 3; k++) chk(req, rd[k], exp_rd(k, a));   // R12 setup-phase data
        @(negedge clk); penable = 1;
        #1;
        for (int k = 0; k < 3; k++) chk(req, rd[k], exp_rd(k, a));
        psel = 0; penable = 0;
        #1;
        chk("R12 idle", rd[0] | rd[1] | rd[2], 32'h0);
    endtask

    task automatic chk_outs(string req);
        for (int k = 0; k < 3; k++) begin
            chk({req, " remap"}, 32'(rmp[k]), var_of(k) != 12'h536 ? 32'(mremap[k]) : 32'h0);
            chk({req, " led"}, 32'(led[k]),
                var_of(k) != 12'h536 ? 32'(mcfg[k][1][NL-1:0]) : 32'h0);
        end
    endtask

    function automatic string tag_of(logic [11:0] a);
        case (a)
            12'h000, 12'h004: return "R2";
            12'h008, 12'h014: return "R3";
            12'h00C: return "R4";
            12'h018, 12'h01C: return "R5";
            12'h010, 12'hFF8, 12'hFFC: return "R6";
            12'h100: return "R10 R11";
            default: return "R7";
        endcase
    endfunction

    logic [11:0] offs [19];
    initial begin
        offs = '{12'h000, 12'h004, 12'h008, 12'h00C, 12'h010, 12'h014, 12'h018, 12'h01C,
                 12'h100, 12'hFF8, 12'hFFC, 12'h020, 12'h09C, 12'h0A0, 12'h0AC,
                 12'h104, 12'hFF4, 12'h0FC, 12'h800};
        for (int k = 0; k < 3; k++) begin
            for (int i = 0; i < 8; i++) mcfg[k][i] = 32'h0;
            mcfg[k][0] = c0r(k);
            mmask[k] = 8'hFF;
            mremap[k] = c0r(k)[0];
        end
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 reset state
        for (int i = 0; i < 19; i++) bus_rd_chk(offs[i], "R1 reset");
        chk("R1 dll copy0", exp_rd(0, 12'h100), 32'hFFFF_0001);
        chk_outs("R1 R8 R9 reset");
        // sweep: write each offset, then read all
        for (int j = 0; j < 19; j++) begin
            logic [31:0] pat;
            pat = {offs[j][7:0] ^ 8'h3C, 8'hC3, 4'h0, offs[j]} ^ (32'(j) * 32'h0101_0107);
            bus_wr(offs[j], pat);
            chk_outs("R8 R9 after write");
            for (int i = 0; i < 19; i++) bus_rd_chk(offs[i], tag_of(offs[i]));
        end
        // R8 remap toggles
        bus_wr(12'h000, 32'h0000_0001); chk_outs("R8 set");
        bus_wr(12'h000, 32'hFFFF_FFFE); chk_outs("R8 clear");
        // R9 led patterns
        for (int p = 0; p < 16; p++) begin
            bus_wr(12'h004, 32'hABCD_0000 | 32'(p)); chk_outs("R9 pattern");
        end
        // R5 write to CFG7 touches nothing else
        bus_wr(12'h018, 32'h6666_6666);
        bus_wr(12'h01C, 32'h7777_7777);
        bus_rd_chk(12'h018, "R5 cfg6 kept");
        bus_rd_chk(12'h01C, "R5 cfg7");
        // R10 R11 mask sweep
        for (int m = 0; m < 256; m++) begin
            bus_wr(12'h100, {8'(m), 24'h5A5A5A});
            bus_rd_chk(12'h100, "R10 R11 mask");
        end
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++; n_tests++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule